// File: doc/BRIEF.md
# PCI Slot Hotplug Status

This block tracks hot-insert and hot-remove events for a bank of up to 32 PCI slots. A platform agent reports each slot event on a small event port, and the block records it in two slot bitmaps: one for slots that came up and one for slots that went down. Only the most recent event is kept. Every hot event first clears both bitmaps and then sets the single bit of the affected slot. Each hot event also sends a one-clock request pulse to the event-status logic, which sets its PCI-hotplug status bit (bit 1 there) from that pulse. Devices that are already present at power-on (coldplug) are reported on the same port but are ignored.

Software reads the two bitmaps as 32-bit words through a small word-addressed register window. It asks for a device to be removed by writing a one-hot slot mask to an eject register. The block picks the lowest set bit of the written mask and emits a one-clock eject strobe that carries that 5-bit slot number. Downstream logic performs the removal itself.

Top module: `hp_slot_status`

## Requirements
- R1: After reset both bitmaps read 0, and `hotplugReq` and `ejectValid` are low.
- R2: A hot insert (`evValid`=1, `evColdplug`=0, `evRemove`=0) for slot s sets the up bitmap to exactly bit s and the down bitmap to 0 at the next clock edge.
- R3: A hot removal (`evValid`=1, `evColdplug`=0, `evRemove`=1) for slot s sets the down bitmap to exactly bit s and the up bitmap to 0 at the next clock edge.
- R4: Each hot event drives `hotplugReq` high for exactly the one cycle after the edge that takes the event.
- R5: An event with `evColdplug`=1 changes neither bitmap and raises no `hotplugReq`.
- R6: `rdData` is combinational from `busAddr`. Offset 0x0 returns the up bitmap and offset 0x4 returns the down bitmap.
- R7: A write with a nonzero value to offset 0x8 (eject) raises `ejectValid` in the cycle after the write edge. `ejectSlot` then holds the index of the lowest set bit of the written value.
- R8: A write of zero to the eject offset produces no eject strobe.
- R9: Reads of offset 0x8 and of every other undecoded offset return 0. Writes to offsets 0x0 and 0x4 change nothing.
- R10: `ejectValid` lasts one clock per eject write. Back-to-back writes give back-to-back strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Slot event present this cycle |
| evSlot | input | 5 | Slot number of the event |
| evRemove | input | 1 | 1 = removal, 0 = insertion |
| evColdplug | input | 1 | 1 = power-on presence, ignored |
| busAddr | input | 4 | Byte offset in the register window |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| rdData | output | 32 | Read data for `busAddr` |
| hotplugReq | output | 1 | One-cycle request to set the PCI-hotplug status bit |
| ejectValid | output | 1 | One-cycle eject strobe |
| ejectSlot | output | 5 | Slot number carried by the eject strobe |

## Verification
The bench goes after the following corner cases:
- A removal that follows an insertion must leave the up bitmap empty. A design that only ORs in new bits would show both bits, or stale bits, at once.
- Coldplug events sent between hot events must leave the previous bitmap readable. A design that treats them as hot events would wipe that bitmap and pulse the request.
- Eject masks with several bits set, bit 31 alone, and zero are driven. A wrong priority encoder picks the highest bit. A design without the zero guard strobes slot 0.
- Writes to the bitmap offsets and reads of the eject offset confirm that the window decodes only the intended words.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  // Byte offsets inside the register window; software depends on these.
  localparam logic [3:0] OFF_UP    = 4'h0;
  localparam logic [3:0] OFF_DOWN  = 4'h4;
  localparam logic [3:0] OFF_EJECT = 4'h8;

  typedef struct packed {
    logic clearMaps;
    logic setUp;
    logic setDown;
    logic ejectFire;
  } ctlStrobes_t;
endpackage

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evValid,
  input  logic              evRemove,
  input  logic              evColdplug,
  input  logic [3:0]        busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output ctlStrobes_t       strobes,
  output logic              hotplugReq
);
  logic hotEvent;

  assign hotEvent = evValid && !evColdplug;

  always_comb begin
    strobes           = '0;
    strobes.clearMaps = hotEvent;
    strobes.setUp     = hotEvent && !evRemove;
    strobes.setDown   = hotEvent && evRemove;
    strobes.ejectFire = busWr && (busAddr == OFF_EJECT) &&
                        (busWdata[NUM_SLOTS-1:0] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hotplugReq <= 1'b0;
    else        hotplugReq <= hotEvent;
  end
endmodule

// File: rtl/hp_slot_datapath.sv
module hp_slot_datapath
  import hp_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctlStrobes_t          strobes,
  input  logic [SLOT_W-1:0]    evSlot,
  input  logic [3:0]           busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [NUM_SLOTS-1:0] upMap,
  output logic [NUM_SLOTS-1:0] downMap,
  output logic [DATA_W-1:0]    rdData,
  output logic                 ejectValid,
  output logic [SLOT_W-1:0]    ejectSlot
);
  logic [NUM_SLOTS-1:0] slotBit;
  logic [SLOT_W-1:0]    lowestIdx;

  assign slotBit = NUM_SLOTS'(1) << evSlot;

  // Lowest set bit wins: scan from the top so lower indices overwrite.
  always_comb begin
    lowestIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (busWdata[i]) lowestIdx = SLOT_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upMap   <= '0;
      downMap <= '0;
    end else if (strobes.clearMaps) begin
      upMap   <= strobes.setUp   ? slotBit : '0;
      downMap <= strobes.setDown ? slotBit : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ejectValid <= 1'b0;
      ejectSlot  <= '0;
    end else begin
      ejectValid <= strobes.ejectFire;
      if (strobes.ejectFire) ejectSlot <= lowestIdx;
    end
  end

  always_comb begin
    unique case (busAddr)
      OFF_UP:   rdData = DATA_W'(upMap);
      OFF_DOWN: rdData = DATA_W'(downMap);
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/hp_slot_status.sv
module hp_slot_status
  import hp_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evValid,
  input  logic [SLOT_W-1:0] evSlot,
  input  logic              evRemove,
  input  logic              evColdplug,
  input  logic [3:0]        busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              hotplugReq,
  output logic              ejectValid,
  output logic [SLOT_W-1:0] ejectSlot
);
  ctlStrobes_t          strobes;
  logic [NUM_SLOTS-1:0] upMap;
  logic [NUM_SLOTS-1:0] downMap;

  hp_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evValid(evValid), .evRemove(evRemove),
    .evColdplug(evColdplug), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .strobes(strobes), .hotplugReq(hotplugReq)
  );

  hp_slot_datapath #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .evSlot(evSlot),
    .busAddr(busAddr), .busWdata(busWdata), .upMap(upMap),
    .downMap(downMap), .rdData(rdData), .ejectValid(ejectValid),
    .ejectSlot(ejectSlot)
  );
endmodule

// File: rtl/hp_slot_checker.sv
module hp_slot_checker #(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 evValid,
  input logic [SLOT_W-1:0]    evSlot,
  input logic                 evRemove,
  input logic                 evColdplug,
  input logic [3:0]           busAddr,
  input logic                 busWr,
  input logic [DATA_W-1:0]    busWdata,
  input logic [DATA_W-1:0]    rdData,
  input logic                 hotplugReq,
  input logic                 ejectValid,
  input logic [SLOT_W-1:0]    ejectSlot,
  input logic [NUM_SLOTS-1:0] upMap,
  input logic [NUM_SLOTS-1:0] downMap
);
  logic [NUM_SLOTS-1:0] pickBit;
  logic [NUM_SLOTS-1:0] belowMask;
  assign pickBit   = NUM_SLOTS'(1) << ejectSlot;
  assign belowMask = pickBit - NUM_SLOTS'(1);

  p_insert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evValid && !evColdplug && !evRemove) |=>
      (upMap == (NUM_SLOTS'(1) << $past(evSlot))) && (downMap == '0));

  p_remove_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evValid && !evColdplug && evRemove) |=>
      (downMap == (NUM_SLOTS'(1) << $past(evSlot))) && (upMap == '0));

  p_req_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hotplugReq) |-> $past(evValid && !evColdplug));

  p_coldplug_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evValid && evColdplug) |=> $stable(upMap) && $stable(downMap) && !hotplugReq);

  p_single_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(upMap | downMap) <= 1);

  p_eject_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ejectValid |-> ((($past(busWdata[NUM_SLOTS-1:0]) & pickBit) != '0) &&
                    (($past(busWdata[NUM_SLOTS-1:0]) & belowMask) == '0)));

  p_eject_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ejectValid |-> $past(busWr && busAddr == 4'h8 && busWdata != '0));

  p_eject_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == 4'h8) |-> (rdData == '0));
endmodule

bind hp_slot_status hp_slot_checker #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evValid(evValid), .evSlot(evSlot),
  .evRemove(evRemove), .evColdplug(evColdplug), .busAddr(busAddr),
  .busWr(busWr), .busWdata(busWdata), .rdData(rdData),
  .hotplugReq(hotplugReq), .ejectValid(ejectValid), .ejectSlot(ejectSlot),
  .upMap(upMap), .downMap(downMap)
);

// File: tb/hp_slot_status_tb.sv
module hp_slot_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evValid = 1'b0;
  logic [4:0]  evSlot = '0;
  logic        evRemove = 1'b0;
  logic        evColdplug = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdData;
  logic        hotplugReq;
  logic        ejectValid;
  logic [4:0]  ejectSlot;

  int checks = 0;
  int errors = 0;
  logic [31:0] expUp = '0;
  logic [31:0] expDown = '0;
  bit done = 0;

  always #5 clk = ~clk;

  hp_slot_status u_dut (
    .clk(clk), .rst_n(rst_n), .evValid(evValid), .evSlot(evSlot),
    .evRemove(evRemove), .evColdplug(evColdplug), .busAddr(busAddr),
    .busWr(busWr), .busWdata(busWdata), .rdData(rdData),
    .hotplugReq(hotplugReq), .ejectValid(ejectValid), .ejectSlot(ejectSlot)
  );

  function automatic logic [4:0] lowestSet(logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) lowestSet = 5'(i);
    if (v == 0) lowestSet = 5'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic checkMaps(string req);
    busAddr = 4'h0; #1 check(req, rdData, expUp);
    busAddr = 4'h4; #1 check(req, rdData, expDown);
  endtask

  // kind: 0 insert, 1 remove, 2 coldplug
  task automatic sendEvent(int kind, logic [4:0] slot);
    @(negedge clk);
    evValid = 1'b1; evSlot = slot;
    evRemove = (kind == 1); evColdplug = (kind == 2);
    @(negedge clk);
    evValid = 1'b0; evRemove = 1'b0; evColdplug = 1'b0;
    if (kind != 2) begin
      expUp = '0; expDown = '0;
      if (kind == 0) expUp[slot] = 1'b1; else expDown[slot] = 1'b1;
      check("R4 req pulse", 32'(hotplugReq), 32'd1);
    end else begin
      check("R5 coldplug no req", 32'(hotplugReq), 32'd0);
    end
    checkMaps(kind == 0 ? "R2 insert maps" : kind == 1 ? "R3 remove maps" : "R5 coldplug maps");
  endtask

  task automatic busWrite(logic [3:0] addr, logic [31:0] data);
    @(negedge clk);
    busWr = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busWr = 1'b0;
    if (addr == 4'h8 && data != 0) begin
      check("R7 eject valid", 32'(ejectValid), 32'd1);
      check("R7 eject slot", 32'(ejectSlot), 32'(lowestSet(data)));
    end else begin
      check("R8 no eject strobe", 32'(ejectValid), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req idle", 32'(hotplugReq), 32'd0);
    check("R1 eject idle", 32'(ejectValid), 32'd0);
    checkMaps("R1 reset maps");
    rst_n = 1'b1;

    // Directed corners
    sendEvent(0, 5'd3);
    @(negedge clk); check("R4 req one cycle", 32'(hotplugReq), 32'd0);
    sendEvent(1, 5'd31);
    sendEvent(2, 5'd7);
    sendEvent(0, 5'd0);
    sendEvent(2, 5'd0);
    busWrite(4'h8, 32'h0000_0000);
    busWrite(4'h8, 32'h8000_0000);
    @(negedge clk); check("R10 eject one cycle", 32'(ejectValid), 32'd0);
    busWrite(4'h8, 32'h0001_0120);
    busWrite(4'h8, 32'hFFFF_FFFF);
    // back-to-back ejects
    @(negedge clk);
    busWr = 1'b1; busAddr = 4'h8; busWdata = 32'h0000_0040;
    @(negedge clk);
    check("R10 first strobe", 32'(ejectValid), 32'd1);
    busWdata = 32'h0000_0400;
    @(negedge clk);
    busWr = 1'b0;
    check("R10 second strobe", 32'(ejectValid), 32'd1);
    check("R10 second slot", 32'(ejectSlot), 32'd10);
    @(negedge clk); check("R10 strobe ends", 32'(ejectValid), 32'd0);
    busWrite(4'h0, 32'hFFFF_FFFF);
    busWrite(4'h4, 32'hFFFF_FFFF);
    checkMaps("R9 map writes ignored");
    busAddr = 4'h8; #1 check("R9 eject reads 0", rdData, 32'd0);
    busAddr = 4'hC; #1 check("R9 undecoded reads 0", rdData, 32'd0);
    checkMaps("R6 map offsets");

    // Random mix with fixed seed
    void'($urandom(32'd20240611));
    for (int n = 0; n < 200; n++) begin
      int pick;
      pick = int'($urandom_range(0, 3));
      if (pick == 3) busWrite(4'h8, (1 << $urandom_range(0, 31)) | ($urandom() & $urandom()));
      else sendEvent(pick, 5'($urandom_range(0, 31)));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule